// File: doc/BRIEF.md
# Adjacent Memory Access Pair Merger

This block sits between the head of a memory-operation queue and a single load/store pipeline whose data path is 128 bits wide. Each cycle it looks at the two oldest queued operations. Two operations merge into one access of twice the width when they are both loads or both stores, share the same size and the same register class (integer or floating point), and sit at adjacent ascending addresses with the lower address aligned to the merged width. Only some pairs merge: two 32-bit integer accesses become one 64-bit access, and two 64-bit integer or two 64-bit floating-point accesses become one 128-bit access. When the pair does not qualify, the older operation goes out alone. Software sees no difference, and a copy loop needs half as many accesses to the pipeline.

Load data returns in issue order on a 128-bit response channel. The block keeps a small in-order record of the loads in flight. A merged load's wide result is split back into two completions, each tagged with the destination tag of its own instruction, in program order.

Top module: `lsb_unit`

## Requirements
- R1: While reset is held and for the cycles after it, `iss_valid` and `cpl_valid` are 0 and `rsp_ready` is 1.
- R2: Two 32-bit integer operations of the same kind (`qN_size`=0, `qN_fp`=0), with slot 1 at slot 0's address plus 4 and slot 0's address a multiple of 8, go out as one access with `iss_bonded`=1 and `iss_size`=1 (64-bit) at slot 0's address, and `deq_cnt`=2 in the cycle the access is accepted.
- R3: Two 64-bit operations (`qN_size`=1) that are both integer or both floating point, of the same kind, with slot 1 at slot 0's address plus 8 and slot 0's address a multiple of 16, go out as one access with `iss_size`=2 (128-bit) and `iss_bonded`=1.
- R4: A 32-bit floating-point operation (`qN_fp`=1, `qN_size`=0) is never merged.
- R5: A pair that mixes a load with a store, integer with floating point, or two sizes, or that is not adjacent and ascending, or whose lower address is misaligned, is not merged: slot 0 goes out alone (`iss_bonded`=0, `iss_size`=`q0_size`), and `deq_cnt`=1 when it is accepted.
- R6: When `q1_valid` is 0, slot 0 goes out alone without waiting.
- R7: Store data on `iss_wdata`: a merged store puts slot 0's data in the low half of the merged width and slot 1's in the high half. A lone 32-bit store carries `q0_wdata[31:0]` in bits 31:0, and a lone 64-bit store carries `q0_wdata` in bits 63:0. All other bits are zero.
- R8: When `LQ_DEPTH` load accesses (a merged pair counts as one) are awaiting a response, `iss_valid` is 0 for a load at slot 0. Stores are not held back by this limit.
- R9: Each load completes exactly once, on `cpl_tag`/`cpl_data`, with its own tag and data zero-extended to 64 bits. The two halves of a merged load complete in consecutive cycles, the older (low half) first.
- R10: A completion appears in the cycle after its response is accepted. `rsp_ready` is 0 only in the cycle after a merged response is accepted, while its second half goes out.
- R11: While `iss_ready` is 0, `deq_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q0_valid | input | 1 | Oldest queue entry present |
| q0_store | input | 1 | Oldest entry is a store |
| q0_fp | input | 1 | Oldest entry is floating point |
| q0_size | input | 2 | Oldest entry size: 0 = 32-bit, 1 = 64-bit |
| q0_addr | input | AW | Oldest entry byte address |
| q0_wdata | input | 64 | Oldest entry store data |
| q0_tag | input | TW | Oldest entry destination tag |
| q1_valid | input | 1 | Second entry present |
| q1_store | input | 1 | Second entry is a store |
| q1_fp | input | 1 | Second entry is floating point |
| q1_size | input | 2 | Second entry size |
| q1_addr | input | AW | Second entry byte address |
| q1_wdata | input | 64 | Second entry store data |
| q1_tag | input | TW | Second entry destination tag |
| deq_cnt | output | 2 | Entries removed from the queue this cycle (0, 1 or 2) |
| iss_valid | output | 1 | Access offered to the load/store pipeline |
| iss_ready | input | 1 | Pipeline accepts the access |
| iss_store | output | 1 | Access is a store |
| iss_fp | output | 1 | Access is floating point |
| iss_size | output | 2 | Access size: 0 = 32, 1 = 64, 2 = 128 bits |
| iss_addr | output | AW | Access byte address |
| iss_wdata | output | 128 | Store data, little-endian |
| iss_bonded | output | 1 | Access covers two operations |
| rsp_valid | input | 1 | Load data returning, in issue order |
| rsp_ready | output | 1 | Block accepts load data |
| rsp_data | input | 128 | Load data, right-aligned |
| cpl_valid | output | 1 | Load completion |
| cpl_tag | output | TW | Tag of the completing load |
| cpl_data | output | 64 | Data of the completing load |

## Verification
A wrong merge decision shows in the same cycle on `iss_bonded`, `iss_size` and, at acceptance, `deq_cnt`. The reference queue then moves out of step with the design, so the mismatches spread over the next cycles. A corrupted in-flight record or split register shows one cycle after the response is accepted, as a wrong tag or half on `cpl_tag`/`cpl_data`, or as a missing second completion. A miscounted in-flight limit shows as `iss_valid` for a load disagreeing with the model's own count of outstanding accesses.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int HALF_W = 64;
  localparam int WIDE_W = 2 * HALF_W;

  typedef enum logic [1:0] {
    SZ_32  = 2'd0,
    SZ_64  = 2'd1,
    SZ_128 = 2'd2
  } acc_size_e;
endpackage

// File: rtl/lsb_pair_check.sv
module lsb_pair_check #(
  parameter int AW = 32
) (
  input  logic          a_valid,
  input  logic          a_store,
  input  logic          a_fp,
  input  logic [1:0]    a_size,
  input  logic [AW-1:0] a_addr,
  input  logic          b_valid,
  input  logic          b_store,
  input  logic          b_fp,
  input  logic [1:0]    b_size,
  input  logic [AW-1:0] b_addr,
  output logic          bond_ok
);
  import lsb_pkg::*;

  logic [AW-1:0] step;
  logic [AW-1:0] align_mask;
  logic          same_kind;
  logic          legal_size;
  logic          adjacent;
  logic          aligned;

  always_comb begin
    step       = AW'(4) << a_size;
    align_mask = (step << 1) - AW'(1);
    same_kind  = (a_store == b_store) && (a_fp == b_fp) && (a_size == b_size);
    legal_size = (a_size == SZ_64) || ((a_size == SZ_32) && !a_fp);
    adjacent   = (b_addr == (a_addr + step));
    aligned    = ((a_addr & align_mask) == '0);
    bond_ok    = a_valid && b_valid && same_kind && legal_size && adjacent && aligned;
  end
endmodule

// File: rtl/lsb_rec_fifo.sv
module lsb_rec_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 14
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (push) wp_n = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
    if (pop)  rp_n = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
    if (push && !pop)      cnt_n = cnt_q + CW'(1);
    else if (pop && !push) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    push |-> !full);
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    pop |-> !empty);
endmodule

// File: rtl/lsb_cpl_split.sv
module lsb_cpl_split #(
  parameter int TW = 6
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic                      rsp_fire,
  input  logic                      rec_bonded,
  input  logic                      rec_narrow,
  input  logic [TW-1:0]             rec_tag_lo,
  input  logic [TW-1:0]             rec_tag_hi,
  input  logic [lsb_pkg::WIDE_W-1:0] rsp_data,
  output logic                      rsp_ready,
  output logic                      cpl_valid,
  output logic [TW-1:0]             cpl_tag,
  output logic [lsb_pkg::HALF_W-1:0] cpl_data
);
  import lsb_pkg::*;

  logic              cpl_v_q, cpl_v_n;
  logic [TW-1:0]     cpl_tag_q, cpl_tag_n;
  logic [HALF_W-1:0] cpl_dat_q, cpl_dat_n;
  logic              cpl_en;
  logic              pend_q, pend_n;
  logic [TW-1:0]     pend_tag_q;
  logic [HALF_W-1:0] pend_dat_q, pend_dat_n;
  logic              pend_en;

  always_comb begin
    cpl_v_n    = 1'b0;
    cpl_tag_n  = cpl_tag_q;
    cpl_dat_n  = cpl_dat_q;
    cpl_en     = 1'b0;
    pend_n     = 1'b0;
    pend_en    = 1'b0;
    pend_dat_n = rec_narrow ? {32'b0, rsp_data[63:32]} : rsp_data[127:64];
    if (pend_q) begin
      cpl_v_n   = 1'b1;
      cpl_en    = 1'b1;
      cpl_tag_n = pend_tag_q;
      cpl_dat_n = pend_dat_q;
    end else if (rsp_fire) begin
      cpl_v_n   = 1'b1;
      cpl_en    = 1'b1;
      cpl_tag_n = rec_tag_lo;
      cpl_dat_n = rec_narrow ? {32'b0, rsp_data[31:0]} : rsp_data[63:0];
      pend_n    = rec_bonded;
      pend_en   = rec_bonded;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cpl_v_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      cpl_v_q <= cpl_v_n;
      pend_q  <= pend_n;
    end
  end

  always_ff @(posedge clk) begin
    if (cpl_en) begin
      cpl_tag_q <= cpl_tag_n;
      cpl_dat_q <= cpl_dat_n;
    end
    if (pend_en) begin
      pend_tag_q <= rec_tag_hi;
      pend_dat_q <= pend_dat_n;
    end
  end

  assign rsp_ready = !pend_q;
  assign cpl_valid = cpl_v_q;
  assign cpl_tag   = cpl_tag_q;
  assign cpl_data  = cpl_dat_q;

  p_two_halves_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_fire && rec_bonded) |=> (cpl_valid && !rsp_ready) ##1 cpl_valid);
  p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_fire |=> cpl_valid);
endmodule

// File: rtl/lsb_unit.sv
module lsb_unit
  import lsb_pkg::*;
#(
  parameter int AW       = 32,
  parameter int TW       = 6,
  parameter int LQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q0_valid,
  input  logic              q0_store,
  input  logic              q0_fp,
  input  logic [1:0]        q0_size,
  input  logic [AW-1:0]     q0_addr,
  input  logic [HALF_W-1:0] q0_wdata,
  input  logic [TW-1:0]     q0_tag,
  input  logic              q1_valid,
  input  logic              q1_store,
  input  logic              q1_fp,
  input  logic [1:0]        q1_size,
  input  logic [AW-1:0]     q1_addr,
  input  logic [HALF_W-1:0] q1_wdata,
  input  logic [TW-1:0]     q1_tag,
  output logic [1:0]        deq_cnt,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic              iss_store,
  output logic              iss_fp,
  output logic [1:0]        iss_size,
  output logic [AW-1:0]     iss_addr,
  output logic [WIDE_W-1:0] iss_wdata,
  output logic              iss_bonded,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [WIDE_W-1:0] rsp_data,
  output logic              cpl_valid,
  output logic [TW-1:0]     cpl_tag,
  output logic [HALF_W-1:0] cpl_data
);
  localparam int RECW = 2 + 2 * TW;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic            bond;
  logic            iss_fire;
  logic            lq_full, lq_empty;
  logic            rec_push, rsp_fire;
  logic [RECW-1:0] rec_in, rec_out;

  lsb_pair_check #(.AW(AW)) u_pair (
    .a_valid (q0_valid), .a_store (q0_store), .a_fp (q0_fp),
    .a_size  (q0_size),  .a_addr  (q0_addr),
    .b_valid (q1_valid), .b_store (q1_store), .b_fp (q1_fp),
    .b_size  (q1_size),  .b_addr  (q1_addr),
    .bond_ok (bond)
  );

  always_comb begin
    iss_valid  = q0_valid && (q0_store || !lq_full);
    iss_fire   = iss_valid && iss_ready;
    deq_cnt    = iss_fire ? (bond ? 2'd2 : 2'd1) : 2'd0;
    iss_store  = q0_store;
    iss_fp     = q0_fp;
    iss_addr   = q0_addr;
    iss_bonded = bond;
    iss_size   = bond ? (q0_size + 2'd1) : q0_size;
    if (bond) begin
      if (q0_size == SZ_32) iss_wdata = {64'b0, q1_wdata[31:0], q0_wdata[31:0]};
      else                  iss_wdata = {q1_wdata, q0_wdata};
    end else begin
      if (q0_size == SZ_32) iss_wdata = {96'b0, q0_wdata[31:0]};
      else                  iss_wdata = {64'b0, q0_wdata};
    end
    rec_push = iss_fire && !q0_store;
    rec_in   = {bond, (q0_size == SZ_32), q0_tag, (bond ? q1_tag : q0_tag)};
    rsp_fire = rsp_valid && rsp_ready;
  end

  lsb_rec_fifo #(.DEPTH(LQ_DEPTH), .W(RECW)) u_recs (
    .clk (clk), .rst_ni (rst_ni),
    .push (rec_push), .din (rec_in),
    .pop (rsp_fire), .dout (rec_out),
    .full (lq_full), .empty (lq_empty)
  );

  lsb_cpl_split #(.TW(TW)) u_split (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .rsp_fire   (rsp_fire),
    .rec_bonded (rec_out[RECW-1]),
    .rec_narrow (rec_out[RECW-2]),
    .rec_tag_lo (rec_out[2*TW-1:TW]),
    .rec_tag_hi (rec_out[TW-1:0]),
    .rsp_data   (rsp_data),
    .rsp_ready  (rsp_ready),
    .cpl_valid  (cpl_valid),
    .cpl_tag    (cpl_tag),
    .cpl_data   (cpl_data)
  );

  p_same_kind_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (iss_valid && iss_bonded) |-> (q1_valid && (q0_store == q1_store)
                                   && (q0_fp == q1_fp) && (q0_size == q1_size)));
  p_fp32_alone_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (iss_valid && q0_fp && (q0_size == SZ_32)) |-> !iss_bonded);
  p_no_lone_pair_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (iss_valid && !q1_valid) |-> (!iss_bonded && (iss_size == q0_size)));
  p_load_limit_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (lq_full && !q0_store) |-> !iss_valid);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    !iss_ready |-> (deq_cnt == 2'd0));
  p_rsp_order_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |-> !lq_empty);
endmodule

// File: tb/lsb_unit_tb.sv
module lsb_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int TW = 6;
  localparam int LQD = 4;
  localparam int SOLO_N = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic q0_valid, q0_store, q0_fp, q1_valid, q1_store, q1_fp;
  logic [1:0] q0_size, q1_size;
  logic [AW-1:0] q0_addr, q1_addr;
  logic [63:0] q0_wdata, q1_wdata;
  logic [TW-1:0] q0_tag, q1_tag;
  logic [1:0] deq_cnt;
  logic iss_valid, iss_ready, iss_store, iss_fp, iss_bonded;
  logic [1:0] iss_size;
  logic [AW-1:0] iss_addr;
  logic [127:0] iss_wdata;
  logic rsp_valid, rsp_ready;
  logic [127:0] rsp_data;
  logic cpl_valid;
  logic [TW-1:0] cpl_tag;
  logic [63:0] cpl_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lsb_unit #(.AW(AW), .TW(TW), .LQ_DEPTH(LQD)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .q0_valid(q0_valid), .q0_store(q0_store), .q0_fp(q0_fp), .q0_size(q0_size),
    .q0_addr(q0_addr), .q0_wdata(q0_wdata), .q0_tag(q0_tag),
    .q1_valid(q1_valid), .q1_store(q1_store), .q1_fp(q1_fp), .q1_size(q1_size),
    .q1_addr(q1_addr), .q1_wdata(q1_wdata), .q1_tag(q1_tag),
    .deq_cnt(deq_cnt), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_store(iss_store), .iss_fp(iss_fp), .iss_size(iss_size),
    .iss_addr(iss_addr), .iss_wdata(iss_wdata), .iss_bonded(iss_bonded),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data)
  );

  int checks = 0;
  int errors = 0;

  logic        op_st [64];
  logic        op_fp [64];
  logic [1:0]  op_sz [64];
  logic [31:0] op_ad [64];
  logic [63:0] op_wd [64];
  int n_ops = 0;
  int n_loads = 0;
  int n_cpl = 0;

  logic [31:0] lq_addr [$];
  int          lq_nb   [$];
  logic        lq_bond [$];
  logic [TW-1:0] eq_tag [$];
  logic [63:0]   eq_dat [$];

  task automatic chk(input string req, input string what, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic add_op(input logic st, input logic fp, input logic [1:0] sz,
                        input logic [31:0] ad);
    op_st[n_ops] = st;
    op_fp[n_ops] = fp;
    op_sz[n_ops] = sz;
    op_ad[n_ops] = ad;
    op_wd[n_ops] = {32'hDEAD0000 | 32'(n_ops), 32'h00BEEF00 | 32'(n_ops)};
    if (!st) n_loads++;
    n_ops++;
  endtask

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [127:0] mread(input logic [31:0] a, input int nb);
    logic [127:0] v = '0;
    for (int i = 0; i < nb; i++) v[8*i +: 8] = mbyte(a + 32'(i));
    return v;
  endfunction

  function automatic logic pair_rule(input int i, input logic v1);
    int b;
    if (!v1) return 1'b0;
    b = 4 << op_sz[i];
    if (op_st[i] != op_st[i+1] || op_fp[i] != op_fp[i+1] || op_sz[i] != op_sz[i+1]) return 1'b0;
    if (op_fp[i] && op_sz[i] == 2'd0) return 1'b0;
    if (op_ad[i+1] != op_ad[i] + 32'(b)) return 1'b0;
    if ((op_ad[i] % (2 * b)) != 0) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    int head = 0;
    int infl = 0;
    int cyc = 0;
    int idle = 0;
    logic f_iss = 0, f_bond = 0, acc_prev = 0, acc_bond = 0, sec_due = 0;
    logic [1:0] f_deq = 0, f_size = 0;
    logic [31:0] f_addr = 0;
    logic f_load = 0;
    logic v0, v1, eb, exp_cpl;
    logic [127:0] ewd;
    string rq;

    add_op(0, 0, 0, 32'h100); add_op(0, 0, 0, 32'h104);
    add_op(0, 0, 0, 32'h200); add_op(0, 0, 0, 32'h204);
    add_op(0, 0, 0, 32'h20C); add_op(0, 0, 0, 32'h210);
    add_op(1, 0, 0, 32'h300); add_op(1, 0, 0, 32'h304);
    add_op(0, 0, 1, 32'h400); add_op(0, 0, 1, 32'h408);
    add_op(0, 1, 1, 32'h500); add_op(0, 1, 1, 32'h508);
    add_op(1, 1, 1, 32'h600); add_op(1, 1, 1, 32'h608);
    add_op(1, 0, 1, 32'h618); add_op(1, 0, 1, 32'h620);
    add_op(0, 1, 0, 32'h700); add_op(0, 1, 0, 32'h704);
    add_op(0, 0, 0, 32'h800); add_op(1, 0, 0, 32'h804);
    add_op(0, 0, 1, 32'h900); add_op(0, 1, 1, 32'h908);
    add_op(0, 0, 0, 32'hA00); add_op(0, 0, 1, 32'hA04);
    add_op(0, 0, 0, 32'hB04); add_op(0, 0, 0, 32'hB00);
    add_op(1, 0, 0, 32'hC00);
    for (int i = 0; i < 8; i++) begin
      add_op(0, 0, 1, 32'h1000 + 32'(16 * i)); add_op(0, 0, 1, 32'h1008 + 32'(16 * i));
      add_op(1, 0, 1, 32'h2000 + 32'(16 * i)); add_op(1, 0, 1, 32'h2008 + 32'(16 * i));
    end

    rst_n = 1'b0;
    q0_valid = 0; q0_store = 0; q0_fp = 0; q0_size = 0; q0_addr = 0; q0_wdata = 0; q0_tag = 0;
    q1_valid = 0; q1_store = 0; q1_fp = 0; q1_size = 0; q1_addr = 0; q1_wdata = 0; q1_tag = 0;
    iss_ready = 0; rsp_valid = 0; rsp_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", "iss_valid in reset", 128'(iss_valid), 128'd0);
    chk("R1", "cpl_valid in reset", 128'(cpl_valid), 128'd0);
    chk("R1", "rsp_ready in reset", 128'(rsp_ready), 128'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "cpl_valid after reset", 128'(cpl_valid), 128'd0);
    chk("R1", "rsp_ready after reset", 128'(rsp_ready), 128'd1);

    while (idle < 6) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog expired");
        break;
      end
      // effects of the last clock edge
      if (f_iss) begin
        for (int k = 0; k < int'(f_deq); k++) begin
          if (!op_st[head]) begin
            eq_tag.push_back(TW'(head));
            eq_dat.push_back(mread(op_ad[head], 4 << op_sz[head]) & 128'hFFFF_FFFF_FFFF_FFFF);
          end
          head++;
        end
        if (f_load) begin
          lq_addr.push_back(f_addr);
          lq_nb.push_back(4 << f_size);
          lq_bond.push_back(f_bond);
          infl++;
        end
      end
      exp_cpl = acc_prev || sec_due;
      sec_due = acc_prev && acc_bond;
      if (acc_prev) begin
        void'(lq_addr.pop_front()); void'(lq_nb.pop_front()); void'(lq_bond.pop_front());
        infl--;
      end
      // new inputs
      v0 = (head < n_ops);
      v1 = (head + 1 < n_ops) && (head >= SOLO_N);
      q0_valid = v0;
      if (v0) begin
        q0_store = op_st[head]; q0_fp = op_fp[head]; q0_size = op_sz[head];
        q0_addr = op_ad[head]; q0_wdata = op_wd[head]; q0_tag = TW'(head);
      end
      q1_valid = v1;
      if (v1) begin
        q1_store = op_st[head+1]; q1_fp = op_fp[head+1]; q1_size = op_sz[head+1];
        q1_addr = op_ad[head+1]; q1_wdata = op_wd[head+1]; q1_tag = TW'(head + 1);
      end
      iss_ready = ($urandom % 4) != 0;
      rsp_valid = (lq_addr.size() > 0) && (($urandom % 3) == 0);
      rsp_data = rsp_valid ? mread(lq_addr[0], lq_nb[0]) : '0;
      acc_bond = rsp_valid ? lq_bond[0] : 1'b0;
      #1;
      // compare against the model
      chk("R10", "rsp_ready", 128'(rsp_ready), 128'(!sec_due));
      chk("R10", "cpl_valid timing", 128'(cpl_valid), 128'(exp_cpl));
      if (cpl_valid) begin
        n_cpl++;
        if (eq_tag.size() == 0) chk("R9", "unexpected completion", 128'(cpl_tag), 128'hX);
        else begin
          chk("R9", "cpl_tag", 128'(cpl_tag), 128'(eq_tag.pop_front()));
          chk("R9", "cpl_data", 128'(cpl_data), eq_dat.pop_front());
        end
      end
      chk("R8", "iss_valid", 128'(iss_valid), 128'(v0 && (op_st[head] || infl < LQD)));
      if (v0) begin
        eb = pair_rule(head, v1);
        if (eb) rq = (op_sz[head] == 2'd1) ? "R3" : "R2";
        else if (op_fp[head] && op_sz[head] == 2'd0) rq = "R4";
        else if (!v1) rq = "R6";
        else rq = "R5";
        chk(rq, "iss_bonded", 128'(iss_bonded), 128'(eb));
        chk(rq, "iss_size", 128'(iss_size), 128'(eb ? op_sz[head] + 2'd1 : op_sz[head]));
        chk(rq, "iss_addr", 128'(iss_addr), 128'(op_ad[head]));
        chk(rq, "iss_store", 128'({iss_store, iss_fp}), 128'({op_st[head], op_fp[head]}));
        if (!iss_ready) chk("R11", "deq_cnt stalled", 128'(deq_cnt), 128'd0);
        else if (iss_valid) chk(rq, "deq_cnt", 128'(deq_cnt), eb ? 128'd2 : 128'd1);
        if (op_st[head]) begin
          if (eb && op_sz[head] == 2'd0) ewd = {64'b0, op_wd[head+1][31:0], op_wd[head][31:0]};
          else if (eb) ewd = {op_wd[head+1], op_wd[head]};
          else if (op_sz[head] == 2'd0) ewd = {96'b0, op_wd[head][31:0]};
          else ewd = {64'b0, op_wd[head]};
          chk("R7", "iss_wdata", iss_wdata, ewd);
        end
      end
      // capture what the next edge does
      f_iss = iss_valid && iss_ready;
      f_deq = deq_cnt;
      f_load = f_iss && !iss_store;
      f_addr = iss_addr;
      f_size = iss_size;
      f_bond = iss_bonded;
      acc_prev = rsp_valid && rsp_ready;
      if (head >= n_ops && lq_addr.size() == 0 && !acc_prev && !sec_due && !f_iss) idle++;
      else idle = 0;
    end

    chk("R9", "completions outstanding", 128'(eq_tag.size()), 128'd0);
    chk("R9", "completion count", 128'(n_cpl), 128'(n_loads));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule